// File: doc/BRIEF.md
# Memory string operation engine

This block runs block-memory string instructions for a processor core. It copies bytes forward or backward, copies up to and including a zero byte, fills memory with a value, scans memory until an element equals a value, scans while elements equal a value, and compares two byte strings. The decoded operation arrives with three 32-bit register values: the destination or first-string pointer (A), the source or second-string pointer or scan/fill value (B), and the remaining element count (N).

After a one-cycle `start` the engine raises `busy` and walks the elements one at a time over a request/acknowledge memory port. After each element it moves the pointers and decrements the count. It stops when that operation's own stop rule is met or when the count reaches zero. It then writes back A, B and N. Scans and compares also update the zero and carry flags. A one-cycle `done` marks the end. Fill and scan accept element sizes of 1, 2 or 4 bytes. Copy and compare always work on bytes.

Top module: `strop_engine`

## Requirements
- R1: After reset `busy`, `done`, `illegal` and `mem_req` are low, and `reg_a`, `reg_b`, `reg_n`, `flag_z` and `flag_c` are zero.
- R2: Operation code 0 (forward copy) and code 2 (backward copy) each move `reg_n` bytes. Each byte is read from address B and written to address A. The code-0 copy adds one to both pointers after each byte and the code-2 copy subtracts one. Both end with N = 0.
- R3: Operation code 1 (copy until zero) copies like code 0 but stops right after it has copied a zero byte. That byte counts against N.
- R4: Operation code 3 (fill) writes the low bytes of B to address A with element width 1 << size for size codes 0, 1 and 2. A advances by that width once per element, and B is left unchanged.
- R5: Operation code 4 (scan until equal) loads elements of width 1 << size from A, advances A by the width and stops on an element equal to B. At the end Z = (last element == B) and C = (last element <= B).
- R6: Operation code 5 (scan while equal) works the same way but stops on an element different from B. At the end Z = (remaining N == 0) and C = (last element <= B).
- R7: Operation code 6 (compare) loads a byte from A and then a byte from B and advances both pointers by one. It stops on a mismatch or when the first byte is zero. At the end Z = (first == second) and C = (first >= second).
- R8: A start with N = 0 ends without any memory request. A and B take the start values, N stays 0, and both flags keep their previous values.
- R9: Size code 3 with fill or scan, and operation code 7, are illegal. The engine pulses `illegal` together with `done`, makes no memory request, and leaves the registers and flags unchanged.
- R10: `done` is high for exactly one cycle and only while `busy` is high. `busy` rises the cycle after an accepted start, and `start` is ignored while `busy` is high.
- R11: Every request holds `mem_req`, `mem_addr`, `mem_we` and `mem_size` steady until `mem_ack`. `mem_size` gives log2 of the access width in bytes, and loaded elements are taken zero-extended from the low bits of `mem_rdata`. Copy and fill make two and one accesses per element, and scan and compare make one and two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 3 | Operation code 0..7 |
| size | input | 2 | Element size code for fill and scan |
| a_in | input | 32 | Start value of pointer A |
| b_in | input | 32 | Start value of B (pointer or value) |
| n_in | input | 32 | Start element count |
| reg_a | output | 32 | Pointer A, final after done |
| reg_b | output | 32 | Register B, final after done |
| reg_n | output | 32 | Remaining count, final after done |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completion was an illegal encoding |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | log2 of access width in bytes |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data, element in low bits |
| mem_rdata | input | 32 | Read data, element in low bits |
| mem_ack | input | 1 | Request completed |

## Verification
The bench goes after stop points that sit one element away from the count limit. These are a zero byte in the middle of a copy, a scan match on the first element, a scan-while run that uses up the count, and a compare that ends on the terminator. An off-by-one in the stop rule would show up as a wrong final N or pointer, or as an extra memory write. Flag formulas are tested in both carry directions and with halfword and word elements. A design that sign-extended or failed to mask loaded data would report a wrong Z or C there. Zero-count and illegal starts are checked for silent flags and for a memory request count of zero. A design that stepped into the loop once would leave its mark in memory and in the access count. A second `start` during a run must not change the result.

// File: rtl/strop_pkg.sv
// Package strop_pkg: shared operation codes and sequencer states for the
// string operation engine. Assumes a 3-bit operation field.
package strop_pkg;
    typedef enum logic [2:0] {
        OP_CPY_F   = 3'd0,
        OP_CPY_Z   = 3'd1,
        OP_CPY_B   = 3'd2,
        OP_FILL    = 3'd3,
        OP_SRCH_EQ = 3'd4,
        OP_SRCH_NE = 3'd5,
        OP_CMP     = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LD0, ST_LD1, ST_STORE, ST_STEP, ST_WB, ST_DONE
    } state_e;
endpackage

// File: rtl/strop_step.sv
// Module strop_step: computes the pointer values after one element.
// Assumes size codes 0..2 for fill and scan; copy and compare are bytewise.
module strop_step
    import strop_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_e             op,
    input  logic [1:0]      size,
    input  logic [XLEN-1:0] ptr_a,
    input  logic [XLEN-1:0] ptr_b,
    output logic [XLEN-1:0] ptr_a_next,
    output logic [XLEN-1:0] ptr_b_next
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    logic [XLEN-1:0] stride;

    // Element stride: one byte, or the element width for fill and scan.
    always_comb begin
        stride = ONE << size;
    end

    // Pointer update rule per operation.
    always_comb begin
        case (op)
            OP_CPY_B: begin
                ptr_a_next = ptr_a - ONE;
                ptr_b_next = ptr_b - ONE;
            end
            OP_FILL, OP_SRCH_EQ, OP_SRCH_NE: begin
                ptr_a_next = ptr_a + stride;
                ptr_b_next = ptr_b;
            end
            default: begin
                ptr_a_next = ptr_a + ONE;
                ptr_b_next = ptr_b + ONE;
            end
        endcase
    end
endmodule

// File: rtl/strop_term.sv
// Module strop_term: decides whether the loop stops after the current
// element and forms the zero and carry flags. Assumes loaded data is
// right-aligned in data0 and byte_b holds the second byte of a pair.
module strop_term
    import strop_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_e             op,
    input  logic [1:0]      size,
    input  logic [XLEN-1:0] data0,
    input  logic [7:0]      byte_b,
    input  logic [XLEN-1:0] value,
    input  logic [XLEN-1:0] count_now,
    output logic            stop,
    output logic            z_new,
    output logic            c_new
);
    logic [XLEN-1:0] emask;
    logic [XLEN-1:0] elem;
    logic [7:0]      byte_a;

    // Zero-extend the loaded element to its width.
    always_comb begin
        emask = '1;
        if (size == 2'd0) emask = XLEN'(8'hFF);
        else if (size == 2'd1) emask = XLEN'(16'hFFFF);
        elem   = data0 & emask;
        byte_a = data0[7:0];
    end

    // Per-operation stop rule.
    always_comb begin
        case (op)
            OP_CPY_Z:   stop = (byte_b == 8'd0);
            OP_SRCH_EQ: stop = (elem == value);
            OP_SRCH_NE: stop = (elem != value);
            OP_CMP:     stop = (byte_a != byte_b) || (byte_a == 8'd0);
            default:    stop = 1'b0;
        endcase
    end

    // Per-operation flag formula at completion.
    always_comb begin
        case (op)
            OP_SRCH_EQ: begin
                z_new = (elem == value);
                c_new = (elem <= value);
            end
            OP_SRCH_NE: begin
                z_new = (count_now == '0);
                c_new = (elem <= value);
            end
            OP_CMP: begin
                z_new = (byte_a == byte_b);
                c_new = (byte_a >= byte_b);
            end
            default: begin
                z_new = 1'b0;
                c_new = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/strop_engine.sv
// Module strop_engine: sequencer for block string operations over a
// request/acknowledge memory port. Assumes the memory answers every
// request with mem_ack in a later cycle and returns data right-aligned.
module strop_engine
    import strop_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [1:0]      size,
    input  logic [XLEN-1:0] a_in,
    input  logic [XLEN-1:0] b_in,
    input  logic [XLEN-1:0] n_in,
    output logic [XLEN-1:0] reg_a,
    output logic [XLEN-1:0] reg_b,
    output logic [XLEN-1:0] reg_n,
    output logic            flag_z,
    output logic            flag_c,
    output logic            busy,
    output logic            done,
    output logic            illegal,
    output logic            mem_req,
    output logic            mem_we,
    output logic [1:0]      mem_size,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ack
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    state_e          state;
    op_e             op_q;
    logic [1:0]      size_q;
    logic [XLEN-1:0] data0_q;
    logic [7:0]      byte_b_q;
    logic            ill_q;
    logic [XLEN-1:0] a_next, b_next;
    logic            stop, z_new, c_new;
    logic            start_ill;
    state_e          first_st;
    op_e             op_in;

    assign op_in = op_e'(op);

    strop_step #(.XLEN(XLEN)) u_step (
        .op(op_q), .size(size_q), .ptr_a(reg_a), .ptr_b(reg_b),
        .ptr_a_next(a_next), .ptr_b_next(b_next)
    );

    strop_term #(.XLEN(XLEN)) u_term (
        .op(op_q), .size(size_q), .data0(data0_q), .byte_b(byte_b_q),
        .value(reg_b), .count_now(reg_n),
        .stop(stop), .z_new(z_new), .c_new(c_new)
    );

    // Illegal encodings: reserved op, or size code 3 on fill or scan.
    always_comb begin
        start_ill = (op_in == OP_RSVD) ||
                    ((size == 2'd3) &&
                     (op_in == OP_FILL || op_in == OP_SRCH_EQ || op_in == OP_SRCH_NE));
    end

    // First access state of one element for the latched operation.
    always_comb begin
        case (op_q)
            OP_FILL:                        first_st = ST_STORE;
            OP_SRCH_EQ, OP_SRCH_NE, OP_CMP: first_st = ST_LD0;
            default:                        first_st = ST_LD1;
        endcase
    end

    // Memory request fields decoded from the current state.
    always_comb begin
        mem_req   = (state == ST_LD0) || (state == ST_LD1) || (state == ST_STORE);
        mem_we    = (state == ST_STORE);
        mem_addr  = (state == ST_LD1) ? reg_b : reg_a;
        mem_size  = ((op_q == OP_FILL || op_q == OP_SRCH_EQ || op_q == OP_SRCH_NE) &&
                     state != ST_LD1) ? size_q : 2'd0;
        mem_wdata = (op_q == OP_FILL) ? reg_b : XLEN'(byte_b_q);
    end

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);
    assign illegal = done && ill_q;

    // Sequencer state, working registers and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= OP_CPY_F;
            size_q   <= 2'd0;
            reg_a    <= '0;
            reg_b    <= '0;
            reg_n    <= '0;
            flag_z   <= 1'b0;
            flag_c   <= 1'b0;
            data0_q  <= '0;
            byte_b_q <= 8'd0;
            ill_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    ill_q <= start_ill;
                    if (start_ill) begin
                        state <= ST_DONE;
                    end else begin
                        op_q   <= op_in;
                        size_q <= size;
                        reg_a  <= a_in;
                        reg_b  <= b_in;
                        reg_n  <= n_in;
                        if (n_in == '0) begin
                            state <= ST_DONE;
                        end else begin
                            case (op_in)
                                OP_FILL:                        state <= ST_STORE;
                                OP_SRCH_EQ, OP_SRCH_NE, OP_CMP: state <= ST_LD0;
                                default:                        state <= ST_LD1;
                            endcase
                        end
                    end
                end
                ST_LD0: if (mem_ack) begin
                    data0_q <= mem_rdata;
                    state   <= (op_q == OP_CMP) ? ST_LD1 : ST_STEP;
                end
                ST_LD1: if (mem_ack) begin
                    byte_b_q <= mem_rdata[7:0];
                    state    <= (op_q == OP_CMP) ? ST_STEP : ST_STORE;
                end
                ST_STORE: if (mem_ack) begin
                    state <= ST_STEP;
                end
                ST_STEP: begin
                    reg_a <= a_next;
                    reg_b <= b_next;
                    reg_n <= reg_n - ONE;
                    state <= (stop || reg_n == ONE) ? ST_WB : first_st;
                end
                ST_WB: begin
                    if (op_q == OP_SRCH_EQ || op_q == OP_SRCH_NE || op_q == OP_CMP) begin
                        flag_z <= z_new;
                        flag_c <= c_new;
                    end
                    state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/strop_chk.sv
// Module strop_chk: protocol and sequencing properties of strop_engine.
// Assumes it is bound into every strop_engine instance.
module strop_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            illegal,
    input logic            mem_req,
    input logic            mem_ack,
    input logic            mem_we,
    input logic [1:0]      mem_size,
    input logic [XLEN-1:0] mem_addr,
    input logic [2:0]      op_q,
    input logic            flag_z,
    input logic            flag_c
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_size)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_illegal_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);

    assert_illegal_no_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_req);

    assert_byte_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (op_q == 3'd0 || op_q == 3'd1 || op_q == 3'd2 || op_q == 3'd6))
        |-> (mem_size == 2'd0));

    assert_flags_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(flag_z) && $stable(flag_c)));
endmodule

bind strop_engine strop_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .illegal(illegal),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .op_q(op_q), .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/sim_strop_engine.sv
// Scoreboard bench: the driver models each operation on a shadow memory
// and queues the expected result; the monitor compares at every done.
module sim_strop_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [1:0]  size = 2'd0;
    logic [31:0] a_in = '0, b_in = '0, n_in = '0;
    logic [31:0] reg_a, reg_b, reg_n;
    logic        flag_z, flag_c, busy, done, illegal;
    logic        mem_req, mem_we;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int nchecks = 0;
    int nerr = 0;
    int acc_cnt = 0;

    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];

    typedef struct {
        logic [31:0] a, b, n;
        logic        z, c, ill;
        int          acc;
    } exp_t;
    exp_t q[$];

    logic [31:0] e_a = '0, e_b = '0, e_n = '0;
    logic        e_z = 1'b0, e_c = 1'b0;

    always #4 clk = ~clk;

    strop_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
        .a_in(a_in), .b_in(b_in), .n_in(n_in),
        .reg_a(reg_a), .reg_b(reg_b), .reg_n(reg_n),
        .flag_z(flag_z), .flag_c(flag_c), .busy(busy), .done(done),
        .illegal(illegal), .mem_req(mem_req), .mem_we(mem_we),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Memory model: acknowledges one cycle after a request, little-endian.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            logic [31:0] t;
            t = '0;
            acc_cnt = acc_cnt + 1;
            for (int k = 0; k < (1 << mem_size); k++) begin
                if (mem_we) mem[8'(mem_addr + 32'(k))] <= mem_wdata[8*k +: 8];
                else t[8*k +: 8] = mem[8'(mem_addr + 32'(k))];
            end
            mem_rdata <= t;
            mem_ack   <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_ref(input logic [31:0] a, input int sz);
        logic [31:0] t = '0;
        for (int k = 0; k < (1 << sz); k++) t[8*k +: 8] = ref_mem[8'(a + 32'(k))];
        return t;
    endfunction

    task automatic poke(input logic [7:0] a, input logic [7:0] v);
        mem[a] = v;
        ref_mem[a] = v;
    endtask

    // Reference model of every operation on the shadow memory.
    task automatic model(input int o, input int sz, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] n, output exp_t e);
        int acc = 0;
        logic [31:0] el = '0;
        logic [7:0]  x = 0, y = 0;
        int eb;
        bit ill;
        ill = (o == 7) || (sz == 3 && (o == 3 || o == 4 || o == 5));
        eb = 1 << sz;
        if (!ill) begin
            while (n != 0) begin
                if (o <= 2) begin
                    x = ref_mem[8'(b)];
                    ref_mem[8'(a)] = x;
                    acc += 2;
                    if (o == 2) begin a--; b--; end else begin a++; b++; end
                    n--;
                    if (o == 1 && x == 0) break;
                end else if (o == 3) begin
                    for (int k = 0; k < eb; k++) ref_mem[8'(a + 32'(k))] = b[8*k +: 8];
                    acc++;
                    a += 32'(eb);
                    n--;
                end else if (o == 4 || o == 5) begin
                    el = rd_ref(a, sz);
                    acc++;
                    a += 32'(eb);
                    n--;
                    if (o == 4 && el == b) break;
                    if (o == 5 && el != b) break;
                end else begin
                    x = ref_mem[8'(a)];
                    y = ref_mem[8'(b)];
                    acc += 2;
                    a++; b++; n--;
                    if (x != y || x == 0) break;
                end
            end
            if (acc != 0) begin
                if (o == 4) begin e_z = (el == b); e_c = (el <= b); end
                if (o == 5) begin e_z = (n == 0);  e_c = (el <= b); end
                if (o == 6) begin e_z = (x == y);  e_c = (x >= y);  end
            end
            e_a = a; e_b = b; e_n = n;
        end
        e.a = e_a; e.b = e_b; e.n = e_n; e.z = e_z; e.c = e_c;
        e.ill = ill; e.acc = acc;
    endtask

    // Driver: queue the expected result, start the engine, wait for the monitor.
    task automatic run(input int o, input int sz, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] n, input bit poke_start);
        exp_t e;
        model(o, sz, a, b, n, e);
        q.push_back(e);
        @(negedge clk);
        acc_cnt = 0;
        start = 1'b1; op = 3'(o); size = 2'(sz); a_in = a; b_in = b; n_in = n;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10", "busy after start", 32'(busy), 32'd1);
        if (poke_start) begin
            @(negedge clk);
            start = 1'b1; op = 3'd3; size = 2'd0; a_in = 32'h10; b_in = 32'h55; n_in = 32'd9;
            @(negedge clk);
            start = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare registers, flags, access count and memory at done.
    initial begin
        forever begin
            @(negedge clk);
            if (done === 1'b1) begin
                exp_t e;
                bit same;
                if (q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
                end else begin
                    e = q.pop_front();
                    chk(reg_a === e.a, "R2-R9 regA", "reg_a", reg_a, e.a);
                    chk(reg_b === e.b, "R4 regB", "reg_b", reg_b, e.b);
                    chk(reg_n === e.n, "R3 count", "reg_n", reg_n, e.n);
                    chk(flag_z === e.z, "R5 R6 R7 zero", "flag_z", 32'(flag_z), 32'(e.z));
                    chk(flag_c === e.c, "R5 R6 R7 carry", "flag_c", 32'(flag_c), 32'(e.c));
                    chk(illegal === e.ill, "R9", "illegal", 32'(illegal), 32'(e.ill));
                    chk(acc_cnt == e.acc, "R11 R8", "access count", 32'(acc_cnt), 32'(e.acc));
                    same = 1'b1;
                    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) same = 1'b0;
                    chk(same, "R2 R3 R4", "memory image", 32'(same), 32'd1);
                    @(negedge clk);
                    chk(done === 1'b0, "R10", "done width", 32'(done), 32'd0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !illegal && !mem_req, "R1", "control outputs",
            {28'd0, busy, done, illegal, mem_req}, 32'd0);
        chk(reg_a == 0 && reg_b == 0 && reg_n == 0 && !flag_z && !flag_c, "R1",
            "registers", reg_a | reg_b | reg_n, 32'd0);
        // R2: forward and backward copy
        run(0, 0, 32'h80, 32'h10, 32'd5, 1'b0);
        run(2, 0, 32'hA4, 32'h24, 32'd4, 1'b0);
        // R3: copy until zero, zero byte at the fourth position
        poke(8'h33, 8'h00);
        run(1, 0, 32'hC0, 32'h30, 32'd8, 1'b0);
        // R4: fill at byte, halfword, word
        run(3, 0, 32'h40, 32'hFFFF_FFA5, 32'd3, 1'b0);
        run(3, 1, 32'h50, 32'h0000_1234, 32'd3, 1'b0);
        run(3, 2, 32'h60, 32'hDEAD_BEEF, 32'd2, 1'b0);
        // R5: scan until equal, match midway and no match
        poke(8'h05, 8'hEE);
        run(4, 0, 32'h00, 32'h0000_00EE, 32'd10, 1'b0);
        run(4, 2, 32'h60, 32'h1111_1111, 32'd2, 1'b0);
        run(4, 1, 32'h50, 32'h0000_1234, 32'd3, 1'b0);
        // R6: scan while equal, mismatch and count exhausted
        run(5, 1, 32'h50, 32'h0000_1234, 32'd5, 1'b0);
        run(5, 1, 32'h50, 32'h0000_1234, 32'd3, 1'b0);
        // R7: compare equal strings, then mismatches both ways
        poke(8'h70, 8'h61); poke(8'h71, 8'h62); poke(8'h72, 8'h00);
        poke(8'h90, 8'h61); poke(8'h91, 8'h62); poke(8'h92, 8'h00);
        run(6, 0, 32'h70, 32'h90, 32'd10, 1'b0);
        poke(8'h78, 8'h61); poke(8'h79, 8'h78);
        poke(8'h98, 8'h61); poke(8'h99, 8'h79);
        run(6, 0, 32'h78, 32'h98, 32'd10, 1'b0);
        run(6, 0, 32'h98, 32'h78, 32'd10, 1'b0);
        // R8: zero count keeps flags and makes no access
        run(4, 0, 32'h20, 32'h0000_0003, 32'd0, 1'b0);
        run(0, 0, 32'h21, 32'h22, 32'd0, 1'b0);
        // R9: illegal encodings
        run(3, 3, 32'h44, 32'h1, 32'd4, 1'b0);
        run(7, 0, 32'h44, 32'h1, 32'd4, 1'b0);
        // R10: start while busy is ignored
        run(0, 0, 32'hE0, 32'h00, 32'd6, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule